// File: doc/BRIEF.md
# Iterative 8-bit Multiply/Divide Unit

This block is the sequential arithmetic unit of an 8-bit core. A one-cycle start pulse hands it an operation select and the operand bytes. It then returns either a 16-bit product or an 8-bit quotient with an 8-bit remainder, together with updated zero, sign and carry flags. The block does the arithmetic one bit per clock: a shift-add loop for multiply and a restoring shift-subtract loop for divide. Before the loop it waits through a decode window, and after the loop it pads to a fixed total latency, so the done strobe always lands on the same cycle the instruction timing promises.

Multiply uses `opa_lo` times `opb`. Divide uses the 16-bit dividend `{opa_hi, opa_lo}` and the divisor `opb`. Result bytes and flags are registered. They change only in the cycle in which `done` is high, and they hold until the next completed operation.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `busy`, `done`, `res_hi`, `res_lo`, `flag_z`, `flag_s` and `flag_c` are all 0.
- R2: When `op_div` is 0 at start, `{res_hi, res_lo}` becomes the unsigned product `opa_lo * opb`, with `res_hi` as the upper byte.
- R3: After a multiply, `flag_z` is 1 exactly when `res_lo` is 0, whatever `res_hi` holds, and `flag_s` and `flag_c` keep their previous values.
- R4: When `op_div` is 1 and `opa_hi < opb`, `res_lo` becomes `{opa_hi,opa_lo} / opb` and `res_hi` becomes `{opa_hi,opa_lo} % opb`.
- R5: After such a divide, `flag_z` is 1 when the quotient is 0, `flag_s` is 1 when the quotient is 0 while the dividend is non-zero, and `flag_c` is 0.
- R6: A divide with `opb` equal to 0, or with `opa_hi >= opb` (quotient wider than 8 bits), gives `res_lo` = 0xFF and `res_hi` = `opa_lo`, with `flag_c` = 1, `flag_z` = 0 and `flag_s` = 0.
- R7: `done` is a one-cycle pulse. It rises on the 19th rising edge after the edge that captured start for a multiply, and on the 26th for a divide. Both counts include a 3-clock decode window. Results and flags are valid when `done` is high and hold until the next `done`.
- R8: `busy` is 1 from the edge that captures start until the edge that raises `done`. It is 0 while `done` is high.
- R9: A start pulse that arrives while `busy` is 1 is ignored. It changes neither the timing nor the results of the operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, taken only when idle |
| op_div | input | 1 | 0 selects multiply, 1 selects divide |
| opa_hi | input | 8 | Dividend high byte (divide only) |
| opa_lo | input | 8 | Multiplicand, or dividend low byte |
| opb | input | 8 | Multiplier, or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| res_hi | output | 8 | Product high byte, or remainder |
| res_lo | output | 8 | Product low byte, or quotient |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign (underflow) flag |
| flag_c | output | 1 | Carry (overflow) flag |

## Verification
Directed multiplies cover several patterns, and each one separates a different fault:
- A zero operand and 255×255 expose a dropped top partial product.
- 16×16 makes the low byte zero while the high byte is not, which separates a low-byte zero flag from a full-width one.

Directed divides cover several more patterns:
- A quotient of 255, a normal quotient with a remainder, and dividends smaller than the divisor (zero and non-zero) separate the zero flag from the sign flag.
- A divisor of zero and a high byte equal to the divisor both exercise the saturated result.

Around these, a seeded random mix alternates the two operations, so carried-over sign and carry flags after a multiply are checked against the preceding divide. Some operations get a second start pulse in mid-flight, to show that a busy unit ignores it.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } md_op_e;

  localparam int unsigned MD_WIDTH   = 8;
  localparam int unsigned MD_DECODE  = 3;
  localparam int unsigned MD_MUL_LAT = 19;
  localparam int unsigned MD_DIV_LAT = 26;
endpackage

// File: rtl/md_seq.sv
module md_seq #(
  parameter int unsigned MUL_LAT = 19,
  parameter int unsigned DIV_LAT = 26,
  parameter int unsigned DECODE  = 3,
  parameter int unsigned STEPS   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic op_div,
  output logic busy,
  output logic done,
  output logic load,
  output logic step,
  output logic finish,
  output logic div_sel
);
  localparam int unsigned AW = $clog2(DIV_LAT + 1);
  localparam logic [AW-1:0] STEP_LO  = AW'(DECODE);
  localparam logic [AW-1:0] STEP_HI  = AW'(DECODE + STEPS);
  localparam logic [AW-1:0] MUL_LAST = AW'(MUL_LAT - 1);
  localparam logic [AW-1:0] DIV_LAST = AW'(DIV_LAT - 1);

  logic [AW-1:0] age;
  logic [AW-1:0] last;

  assign load   = start && !busy;
  assign last   = div_sel ? DIV_LAST : MUL_LAST;
  assign step   = busy && (age >= STEP_LO) && (age < STEP_HI);
  assign finish = busy && (age == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      age     <= '0;
      div_sel <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy    <= 1'b1;
        age     <= '0;
        div_sel <= op_div;
      end else if (busy) begin
        age <= age + 1'b1;
        if (age == last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_STEP_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    step |-> busy && !finish) else $error("step outside busy window");  // R7
endmodule

// File: rtl/md_mul.sv
module md_mul #(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  logic [W-1:0] hi;
  logic [W-1:0] lo;
  logic [W-1:0] mcand;
  logic [W:0]   sum;

  assign sum  = {1'b0, hi} + (lo[0] ? {1'b0, mcand} : '0);
  assign prod = {hi, lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi    <= '0;
      lo    <= '0;
      mcand <= '0;
    end else if (load) begin
      hi    <= '0;
      lo    <= b;
      mcand <= a;
    end else if (step) begin
      hi <= sum[W:1];
      lo <= {sum[0], lo[W-1:1]};
    end
  end
endmodule

// File: rtl/md_div.sv
module md_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] num_hi,
  input  logic [W-1:0] num_lo,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         ovf
);
  logic [W-1:0] part;
  logic [W-1:0] q;
  logic [W-1:0] d;
  logic [W:0]   trial;
  logic [W-1:0] diff;
  logic         fits;

  assign trial = {part, q[W-1]};
  assign fits  = trial >= {1'b0, d};
  assign diff  = trial[W-1:0] - d;
  assign quo   = ovf ? '1 : q;
  assign rem   = ovf ? q : part;

  always_ff @(posedge clk) begin
    if (rst) begin
      part <= '0;
      q    <= '0;
      d    <= '0;
      ovf  <= 1'b0;
    end else if (load) begin
      part <= num_hi;
      q    <= num_lo;
      d    <= den;
      ovf  <= (num_hi >= den);
    end else if (step && !ovf) begin
      part <= fits ? diff : trial[W-1:0];
      q    <= {q[W-2:0], fits};
    end
  end

  AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (rst)
    (!ovf && d != '0) |-> part < d) else $error("partial remainder too large");  // R4
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int unsigned W       = MD_WIDTH,
  parameter int unsigned DECODE  = MD_DECODE,
  parameter int unsigned MUL_LAT = MD_MUL_LAT,
  parameter int unsigned DIV_LAT = MD_DIV_LAT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op_div,
  input  logic [W-1:0] opa_hi,
  input  logic [W-1:0] opa_lo,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo,
  output logic         flag_z,
  output logic         flag_s,
  output logic         flag_c
);
  logic           load, step, finish, div_sel;
  logic [2*W-1:0] prod;
  logic [W-1:0]   quo, rem;
  logic           ovf;

  md_seq #(
    .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT), .DECODE(DECODE), .STEPS(W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .op_div(op_div),
    .busy(busy), .done(done), .load(load), .step(step),
    .finish(finish), .div_sel(div_sel)
  );

  md_mul #(.W(W)) u_mul (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .a(opa_lo), .b(opb), .prod(prod)
  );

  md_div #(.W(W)) u_div (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .num_hi(opa_hi), .num_lo(opa_lo), .den(opb),
    .quo(quo), .rem(rem), .ovf(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_hi <= '0;
      res_lo <= '0;
      flag_z <= 1'b0;
      flag_s <= 1'b0;
      flag_c <= 1'b0;
    end else if (finish) begin
      if (div_sel == OP_DIV) begin
        res_hi <= rem;
        res_lo <= quo;
        flag_z <= (quo == '0);
        flag_s <= !ovf && (quo == '0) && (rem != '0);
        flag_c <= ovf;
      end else begin
        res_hi <= prod[2*W-1:W];
        res_lo <= prod[W-1:0];
        flag_z <= (prod[W-1:0] == '0);
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle");  // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy) else $error("busy during done");  // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !finish) |=> busy) else $error("start restarted busy unit");  // R9
  AST_MUL_ZLOW: assert property (@(posedge clk) disable iff (rst)
    (done && !div_sel) |-> flag_z == (res_lo == '0)) else $error("mul zero flag");  // R3
  AST_MUL_KEEP_SC: assert property (@(posedge clk) disable iff (rst)
    (done && !div_sel) |-> (flag_s == $past(flag_s) && flag_c == $past(flag_c)))
    else $error("mul touched sign/carry");  // R3
  AST_DIV_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (done && div_sel && flag_c) |-> (res_lo == '1 && !flag_z && !flag_s))
    else $error("overflow result not saturated");  // R6
endmodule

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       op_div = 1'b0;
  logic [7:0] opa_hi = '0, opa_lo = '0, opb = '0;
  logic       busy, done, flag_z, flag_s, flag_c;
  logic [7:0] res_hi, res_lo;

  int checks = 0;
  int errors = 0;
  logic e_z = 1'b0, e_s = 1'b0, e_c = 1'b0;

  always #4 clk = ~clk;

  muldiv_unit u0 (
    .clk(clk), .rst(rst), .start(start), .op_div(op_div),
    .opa_hi(opa_hi), .opa_lo(opa_lo), .opb(opb),
    .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo),
    .flag_z(flag_z), .flag_s(flag_s), .flag_c(flag_c)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic run_op(input logic d, input logic [7:0] h, input logic [7:0] l,
                        input logic [7:0] b, input bit poke);
    int lat;
    bit tim_ok;
    logic [7:0] x_hi, x_lo;
    logic [15:0] n;
    lat = d ? 26 : 19;
    // expected values from the requirements
    if (!d) begin
      {x_hi, x_lo} = 16'(l) * 16'(b);  // R2
      e_z = (x_lo == 8'h00);           // R3, S and C kept
    end else if (b == 8'h00 || h >= b) begin
      x_lo = 8'hFF; x_hi = l;          // R6
      e_z = 1'b0; e_s = 1'b0; e_c = 1'b1;
    end else begin
      n = {h, l};
      x_lo = 8'(n / 16'(b)); x_hi = 8'(n % 16'(b));  // R4
      e_z = (x_lo == 8'h00); e_s = (x_lo == 8'h00) && (n != 16'h0); e_c = 1'b0;  // R5
    end
    @(negedge clk);
    start = 1'b1; op_div = d; opa_hi = h; opa_lo = l; opb = b;
    @(negedge clk);
    start = 1'b0;
    opa_hi = 8'($urandom); opa_lo = 8'($urandom); opb = 8'($urandom); op_div = !d;
    tim_ok = busy && !done;
    for (int j = 1; j <= lat + 1; j++) begin
      if (poke && j == 5) start = 1'b1;   // R9 start while busy
      if (poke && j == 6) start = 1'b0;
      @(negedge clk);
      if (busy != (j < lat) || done != (j == lat)) tim_ok = 1'b0;
      if (j == lat) begin
        chk(res_hi == x_hi, d ? "R4/R6 remainder" : "R2 product high", int'(res_hi), int'(x_hi));
        chk(res_lo == x_lo, d ? "R4/R6 quotient" : "R2 product low", int'(res_lo), int'(x_lo));
        chk({flag_z, flag_s, flag_c} == {e_z, e_s, e_c}, d ? "R5/R6 flags zsc" : "R3 flags zsc",
            int'({flag_z, flag_s, flag_c}), int'({e_z, e_s, e_c}));
      end
    end
    chk(tim_ok, poke ? "R9 R7 R8 timing with ignored start" : "R7 R8 timing", int'(tim_ok), 1);
    chk(res_hi == x_hi && res_lo == x_lo, "R7 results held", int'({res_hi, res_lo}), int'({x_hi, x_lo}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1 busy/done", int'({busy, done}), 0);
    chk(res_hi == 0 && res_lo == 0, "R1 results", int'({res_hi, res_lo}), 0);
    chk({flag_z, flag_s, flag_c} == 3'b000, "R1 flags", int'({flag_z, flag_s, flag_c}), 0);
    // directed corner cases
    run_op(1'b0, 8'h00, 8'h00, 8'h5A, 1'b0);  // R2 zero operand
    run_op(1'b0, 8'h00, 8'hFF, 8'hFF, 1'b0);  // R2 largest product
    run_op(1'b0, 8'h00, 8'h10, 8'h10, 1'b1);  // R3 low byte zero, high not
    run_op(1'b1, 8'h03, 8'hE8, 8'h07, 1'b0);  // R4 1000/7
    run_op(1'b1, 8'h00, 8'h05, 8'h09, 1'b0);  // R5 sign set
    run_op(1'b0, 8'h00, 8'h03, 8'h04, 1'b0);  // R3 S kept from divide
    run_op(1'b1, 8'h00, 8'h00, 8'h09, 1'b0);  // R5 zero dividend
    run_op(1'b1, 8'h12, 8'h34, 8'h00, 1'b1);  // R6 divide by zero
    run_op(1'b0, 8'h00, 8'h02, 8'h03, 1'b0);  // R3 C kept from divide
    run_op(1'b1, 8'h09, 8'h77, 8'h09, 1'b0);  // R6 quotient overflow
    run_op(1'b1, 8'hFE, 8'hFF, 8'hFF, 1'b0);  // R4 quotient 255
    // seeded random mix
    for (int k = 0; k < 60; k++) begin
      logic [7:0] b;
      b = 8'($urandom);
      run_op(1'($urandom), 8'($urandom % 32'(b + 9'd1)), 8'($urandom), b, (k % 5) == 2);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule